// File: doc/BRIEF.md
# Dual-Channel Safety Interlock Monitor

This block supervises a light curtain inside one clock domain. It takes two redundant beam-clear channels, the feedback loop formed by the series normally-closed contacts of both load contactors, and a manual restart pushbutton. From these it produces a healthy flag, an enable-to-start interlock, two contactor drive lines that follow the interlock, a latched channel fault and a saturating count of restart attempts. The block monitors and gates. It is not a certified safety function.

All four inputs pass through two-flop synchronizers. A state machine with four states decides the interlock and the fault:

- `ST_IDLE`: interlock off, no fault. It moves to `ST_RUN` on a restart edge while healthy. It moves to `ST_FAULT` when the discrepancy window expires.
- `ST_RUN`: interlock on. It falls back to `ST_IDLE` when healthy drops. It moves to `ST_FAULT` when the discrepancy window expires.
- `ST_FAULT`: the fault is latched. It moves to `ST_FAULT_CLR` once both channels read low in the same cycle.
- `ST_FAULT_CLR`: the fault is still latched. It moves to `ST_IDLE` on a restart edge while healthy. It returns to `ST_FAULT` if the discrepancy window expires again.

A discrepancy timer counts consecutive cycles in which the channels disagree, and it restarts whenever they agree.

Top module: `safety_interlock_monitor`

## Requirements
- R1: `healthy_o` is 1 exactly when the synchronized channel A, channel B and feedback are all 1. An input change reaches `healthy_o` two clock edges after it is applied.
- R2: `interlock_o` rises only on a synchronized 0-to-1 edge of `reset_btn_i` that arrives while `healthy_o` is 1 and no fault is latched.
- R3: `interlock_o` goes to 0 in the same cycle that `healthy_o` goes to 0.
- R4: A restart button held at 1 never sets the interlock again after it clears. A fresh 0-to-1 edge is required.
- R5: While feedback is 0, restart edges are ignored and `interlock_o` stays 0.
- R6: When the synchronized channels differ for `DISC_CYCLES` consecutive cycles, `fault_o` latches to 1 and the interlock is held at 0. A shorter mismatch, or one broken by a single cycle of agreement, latches no fault.
- R7: A latched fault ignores restart edges until both channels have read 0 together. After that, a restart edge while healthy clears `fault_o`, and that same edge leaves `interlock_o` at 0.
- R8: `drive_a_o` and `drive_b_o` both equal `interlock_o`.
- R9: `attempts_o` increments by one on every synchronized restart edge, whether or not the edge is accepted. It saturates at 2^`CNT_W`-1.
- R10: While `rst` is 1, `interlock_o`, both drives and `fault_o` are 0. A system reset clears `attempts_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| chan_a_i | input | 1 | Beam-clear channel A (1 = clear) |
| chan_b_i | input | 1 | Beam-clear channel B (1 = clear) |
| fdbk_i | input | 1 | Contactor feedback loop (1 = both contactors released) |
| reset_btn_i | input | 1 | Manual restart pushbutton |
| healthy_o | output | 1 | Both channels and feedback asserted |
| interlock_o | output | 1 | Enable-to-start |
| drive_a_o | output | 1 | Contactor drive, first channel |
| drive_b_o | output | 1 | Contactor drive, second channel |
| fault_o | output | 1 | Latched channel discrepancy fault |
| attempts_o | output | CNT_W | Saturating count of restart edges |

## Verification
The bench builds the block with `DISC_CYCLES` = 8 and `CNT_W` = 4. With these values the bench can sweep every mismatch length from 1 to 12 cycles and check the fault boundary exactly at 8. It can also drive the attempt counter well past its saturation value of 15 within a few hundred cycles. All eight input combinations are swept for the healthy flag. The hold, feedback-open and fault-recovery restart sequences are each driven explicitly.

// File: rtl/sim_pkg.sv
package sim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RUN       = 2'd1,
        ST_FAULT     = 2'd2,
        ST_FAULT_CLR = 2'd3
    } sim_state_e;
endpackage

// File: rtl/sim_sync.sv
module sim_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/sim_disc_timer.sv
module sim_disc_timer #(
    parameter int DISC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic mismatch_i,
    output logic timeout_o
);
    localparam int CW = (DISC_CYCLES > 1) ? $clog2(DISC_CYCLES) : 1;
    localparam logic [CW-1:0] LIM = CW'(DISC_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !mismatch_i) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign timeout_o = mismatch_i && (cnt == LIM);

    // R6: agreement restarts the window
    a_r6_timer_restart: assert property (@(posedge clk) disable iff (rst)
        !mismatch_i |=> (cnt == '0));
    // R6: the count grows one step per mismatching cycle below the limit
    a_r6_timer_step: assert property (@(posedge clk) disable iff (rst)
        (mismatch_i && cnt != LIM) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sim_attempt_cnt.sv
module sim_attempt_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_i,
    output logic             edge_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
        end else begin
            prev <= btn_i;
        end
    end

    assign edge_o = btn_i && !prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (edge_o && count_o != MAXV) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R9: saturation holds
    a_r9_hold_max: assert property (@(posedge clk) disable iff (rst)
        (count_o == MAXV) |=> (count_o == MAXV));
    // R9: each edge below saturation adds one
    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        (edge_o && count_o != MAXV) |=> (count_o == $past(count_o) + 1'b1));
    // R9: no edge, no change
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !edge_o |=> $stable(count_o));
endmodule

// File: rtl/safety_interlock_monitor.sv
module safety_interlock_monitor
    import sim_pkg::*;
#(
    parameter int DISC_CYCLES = 5_000_000,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_a_i,
    input  logic             chan_b_i,
    input  logic             fdbk_i,
    input  logic             reset_btn_i,
    output logic             healthy_o,
    output logic             interlock_o,
    output logic             drive_a_o,
    output logic             drive_b_o,
    output logic             fault_o,
    output logic [CNT_W-1:0] attempts_o
);
    localparam int NIN = 4;

    logic [NIN-1:0] raw, syn;
    logic           a_s, b_s, fb_s, btn_s;
    logic           healthy, btn_edge, timeout, both_low;
    sim_state_e     state, state_nx;

    assign raw = {reset_btn_i, fdbk_i, chan_b_i, chan_a_i};

    sim_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (raw),
        .q_o (syn)
    );

    assign a_s   = syn[0];
    assign b_s   = syn[1];
    assign fb_s  = syn[2];
    assign btn_s = syn[3];

    assign healthy  = a_s && b_s && fb_s;
    assign both_low = !a_s && !b_s;

    sim_disc_timer #(.DISC_CYCLES(DISC_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .mismatch_i (a_s ^ b_s),
        .timeout_o  (timeout)
    );

    sim_attempt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .btn_i   (btn_s),
        .edge_o  (btn_edge),
        .count_o (attempts_o)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (timeout)                    state_nx = ST_FAULT;
                else if (btn_edge && healthy)   state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (timeout)                    state_nx = ST_FAULT;
                else if (!healthy)              state_nx = ST_IDLE;
            end
            ST_FAULT: begin
                if (both_low)                   state_nx = ST_FAULT_CLR;
            end
            ST_FAULT_CLR: begin
                if (timeout)                    state_nx = ST_FAULT;
                else if (btn_edge && healthy)   state_nx = ST_IDLE;
            end
            default:                            state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        healthy_o   = healthy;
        interlock_o = (state == ST_RUN) && healthy && !rst;
        drive_a_o   = interlock_o;
        drive_b_o   = interlock_o;
        fault_o     = ((state == ST_FAULT) || (state == ST_FAULT_CLR)) && !rst;
    end

    // R2: entry to the run state needs a restart edge while healthy
    a_r2_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN) |-> $past(btn_edge && healthy));
    // R3: loss of health leaves the run state
    a_r3_drop_leaves_run: assert property (@(posedge clk) disable iff (rst)
        !healthy |=> (state != ST_RUN));
    // R7: a latched fault stays latched until the recovery state is left
    a_r7_fault_persists: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT) |=> fault_o);
    // R7: fault clearing needs a healthy restart edge
    a_r7_clear_needs_edge: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_FAULT_CLR) |-> $past(btn_edge && healthy));
    // R6: a latched fault keeps the interlock off
    a_r6_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !interlock_o);
endmodule

// File: tb/safety_interlock_monitor_bench.sv
`timescale 1ns/1ps
module safety_interlock_monitor_bench;
    localparam int DISC  = 8;
    localparam int CW    = 4;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b1, b = 1'b1, fb = 1'b1, btn = 1'b0;
    logic healthy, ilk, drv_a, drv_b, fault;
    logic [CW-1:0] att;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    safety_interlock_monitor #(.DISC_CYCLES(DISC), .CNT_W(CW)) u_safety_interlock_monitor (
        .clk (clk), .rst (rst),
        .chan_a_i (a), .chan_b_i (b), .fdbk_i (fb), .reset_btn_i (btn),
        .healthy_o (healthy), .interlock_o (ilk),
        .drive_a_o (drv_a), .drive_b_o (drv_b),
        .fault_o (fault), .attempts_o (att)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_ilk(input string req, input int exp);
        check(ilk == exp, req, ilk, exp);
        check(drv_a == exp && drv_b == exp, "R8", {drv_a, drv_b}, exp * 3);
    endtask

    task automatic press();
        btn = 1'b1; step(4);
        btn = 1'b0; step(4);
        if (exp_cnt < CMAX) exp_cnt++;
    endtask

    task automatic sys_reset();
        rst = 1'b1; step(3);
        check(ilk == 0 && drv_a == 0 && drv_b == 0, "R10", {ilk, drv_a, drv_b}, 0);
        check(fault == 0, "R10", fault, 0);
        rst = 1'b0; step(1);
        check(att == 0, "R10", att, 0);
        exp_cnt = 0;
    endtask

    task automatic clear_fault();
        a = 1'b0; b = 1'b0; step(4);
        a = 1'b1; b = 1'b1; fb = 1'b1; step(4);
        press();
        check(fault == 0, "R7", fault, 0);
        chk_ilk("R7", 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1);
        sys_reset();
        step(3);
        chk_ilk("R10", 0);

        // R1: all input combinations, with a 2-edge latency
        for (int i = 0; i < 8; i++) begin
            a = i[2]; b = i[1]; fb = i[0];
            step(1);
            check(healthy == 1'b1, "R1", healthy, 1);
            step(1);
            check(healthy == (i == 7), "R1", healthy, int'(i == 7));
            step(2);
            a = 1'b1; b = 1'b1; fb = 1'b1; step(4);
        end
        check(fault == 0, "R6", fault, 0);

        // R2: restart while healthy
        chk_ilk("R2", 0);
        press();
        chk_ilk("R2", 1);
        check(att == exp_cnt, "R9", att, exp_cnt);

        // R3: interlock drops in the same cycle as healthy
        a = 1'b0; step(1);
        chk_ilk("R3", 1);
        step(1);
        check(healthy == 0, "R3", healthy, 0);
        chk_ilk("R3", 0);
        a = 1'b1; step(4);
        chk_ilk("R3", 0);

        // R4: held button does not re-arm
        press();
        chk_ilk("R2", 1);
        btn = 1'b1; step(4);
        if (exp_cnt < CMAX) exp_cnt++;
        a = 1'b0; step(4);
        a = 1'b1; step(8);
        chk_ilk("R4", 0);
        btn = 1'b0; step(4);
        chk_ilk("R4", 0);
        press();
        chk_ilk("R4", 1);

        // R5: open feedback blocks restart, attempts still counted
        fb = 1'b0; step(3);
        chk_ilk("R5", 0);
        press();
        chk_ilk("R5", 0);
        check(att == exp_cnt, "R9", att, exp_cnt);
        fb = 1'b1; step(4);
        chk_ilk("R5", 0);

        // R6: mismatch length sweep around the window
        for (int n = 1; n <= 12; n++) begin
            if (n[0]) b = 1'b0; else a = 1'b0;
            step(n);
            a = 1'b1; b = 1'b1; step(4);
            check(fault == (n >= DISC), "R6", fault, int'(n >= DISC));
            if (fault) begin
                chk_ilk("R6", 0);
                press();
                check(fault == 1, "R7", fault, 1);
                chk_ilk("R7", 0);
                clear_fault();
                press();
                chk_ilk("R7", 1);
                a = 1'b0; b = 1'b0; step(1); a = 1'b1; b = 1'b1; step(4);
            end
        end

        // R6: one cycle of agreement restarts the window
        b = 1'b0; step(DISC - 2);
        b = 1'b1; step(1);
        b = 1'b0; step(DISC - 2);
        b = 1'b1; step(4);
        check(fault == 0, "R6", fault, 0);

        // R6: fault while running forces interlock low
        press();
        chk_ilk("R2", 1);
        a = 1'b0; step(DISC + 4);
        a = 1'b1; step(4);
        check(fault == 1, "R6", fault, 1);
        chk_ilk("R6", 0);

        // R10: system reset clears the fault
        sys_reset();
        step(3);
        check(fault == 0, "R10", fault, 0);

        // R9: saturation sweep
        for (int k = 1; k <= CMAX + 5; k++) begin
            press();
            check(att == ((k < CMAX) ? k : CMAX), "R9", att, (k < CMAX) ? k : CMAX);
        end

        // R10: reset while running
        check(ilk == 1, "R2", ilk, 1);
        rst = 1'b1; step(1);
        chk_ilk("R10", 0);
        step(2);
        rst = 1'b0; step(1);
        check(att == 0, "R10", att, 0);
        step(3);
        chk_ilk("R10", 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule